// File: doc/BRIEF.md
# Synchronous Parallel FIFO Bridge Controller

This block is the FPGA-side master for a half-duplex, byte-wide synchronous FIFO link to a USB bridge device. It runs entirely on the clock that the device supplies. One data bus carries traffic in both directions. Received bytes are drained into a user output stream with back-pressure, and bytes from a user input stream are written to the device. The pad-level tri-state is outside the block: it gives the incoming bus value, the outgoing byte and a drive-enable.

The device reports data waiting with an active-low receive flag and free space with an active-low transmit flag. Before a read, the controller drops the output-enable strobe for one cycle so that the device can take over the bus. It then holds the read strobe low to burst, or raises it to wait. A write counts only on an edge where the write strobe and the transmit flag are both low. A byte presented while the device is full is kept and presented again later. Reads win arbitration. A write visit ends after a parameterised number of accepted bytes, so that a waiting read is not starved.

Top module: `fifo_bridge_ctrl`

## Requirements
- R1: While reset is low, and in the cycles after it until a transfer begins, dev_rd_n, dev_wr_n and dev_oe_n are 1 and bus_drive is 0. A byte held for retry when reset arrives is discarded and never written.
- R2: A received byte is taken only on an edge where dev_rd_n and dev_rxf_n are both 0. Bytes reach rx_data in the order the device supplied them, each exactly once. Bus values seen while dev_rxf_n is 1 are never forwarded.
- R3: dev_rd_n goes low only while dev_oe_n is low. The first cycle with dev_oe_n low has dev_rd_n high. A read visit starts only after dev_rxf_n was sampled 0.
- R4: A transmitted byte counts only on an edge where dev_wr_n and dev_txe_n are both 0. The bytes accepted by the device equal the bytes handed over by tx_valid/tx_ready, in order, each exactly once.
- R5: rx_valid, once high, stays high with rx_data unchanged until a cycle with rx_ready high. Each such cycle consumes exactly one byte.
- R6: bus_drive (1 = FPGA drives the bus) is high only during a write visit and never while dev_oe_n is 0. Between directions there is at least one cycle with dev_oe_n at 1 and bus_drive at 0.
- R7: In any cycle with rx_valid 1 and rx_ready 0, dev_rd_n is 1.
- R8: A write visit (bus_drive rising) starts only if, in the previous cycle, dev_rxf_n was 1 and dev_txe_n was 0.
- R9: With MAX_BURST > 0, no write visit has more than MAX_BURST accepted bytes.
- R10: If a byte is presented with dev_wr_n 0 while dev_txe_n is 1, bus_out keeps that byte on the next cycle. The same byte is accepted on a later write visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the bridge device |
| rst_n | input | 1 | Active-low reset |
| dev_rxf_n | input | 1 | Device has a byte to read (active low) |
| dev_txe_n | input | 1 | Device can take a byte (active low) |
| dev_rd_n | output | 1 | Read strobe (active low) |
| dev_wr_n | output | 1 | Write strobe (active low) |
| dev_oe_n | output | 1 | Device bus output enable (active low) |
| bus_in | input | DATA_W | Value on the shared data bus |
| bus_out | output | DATA_W | Byte to drive onto the bus |
| bus_drive | output | 1 | 1 = FPGA drivers enabled |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | User accepts the received byte |
| rx_data | output | DATA_W | Received byte |
| tx_valid | input | 1 | User offers a byte to send |
| tx_ready | output | 1 | Controller takes the offered byte |
| tx_data | input | DATA_W | Byte to send |

## Verification
A retry flag left set, or a lost one, shows at the device edge as a byte written twice or never. The device-side scoreboard reports it at the first later accepted write, within a few cycles. A sequencer stuck in a wrong state shows in the same cycle as bus_drive overlapping a low dev_oe_n, or a read strobe during back-pressure. These are caught on the clock where they happen. A receive register that loads on the wrong edge forwards the invalid bus marker or drops a byte. The next consumed rx_data then mismatches the ordered reference queue.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_RD_TURN = 2'd1,
      ST_RD      = 2'd2,
      ST_WR      = 2'd3
   } fbc_state_t;

   function automatic int unsigned fbc_cnt_width(input int unsigned limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/fbc_sequencer.sv
module fbc_sequencer
   import fbc_pkg::*;
#(
   parameter int unsigned MAX_BURST = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxf_n,
   input  logic       txe_n,
   input  logic       wr_pending,
   input  logic       hold_next,
   input  logic       wr_fire,
   output fbc_state_t state
);
   localparam int unsigned CW = fbc_cnt_width(MAX_BURST);

   fbc_state_t state_q, state_d;
   logic       limit_hit;

   generate
      if (MAX_BURST == 0) begin : g_unlimited
         assign limit_hit = 1'b0;
      end else begin : g_limited
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] cnt_inc;
         assign cnt_inc   = cnt_q + CW'(wr_fire);
         assign limit_hit = wr_fire && (cnt_inc == CW'(MAX_BURST));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 cnt_q <= '0;
            else if (state_q != ST_WR)  cnt_q <= '0;
            else                        cnt_q <= cnt_inc;
         end
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            if (!rxf_n)                     state_d = ST_RD_TURN;
            else if (!txe_n && wr_pending)  state_d = ST_WR;
         end
         ST_RD_TURN:                        state_d = ST_RD;
         ST_RD:      if (rxf_n)             state_d = ST_IDLE;
         ST_WR:      if (txe_n || !hold_next || limit_hit) state_d = ST_IDLE;
         default:                           state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/fbc_rx_stage.sv
module fbc_rx_stage #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_window,
   input  logic              rxf_n,
   input  logic [DATA_W-1:0] bus_in,
   input  logic              rx_ready,
   output logic              rd_n,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data
);
   logic              valid_q;
   logic [DATA_W-1:0] data_q;
   logic              slot_free;
   logic              take;

   assign slot_free = !valid_q || rx_ready;
   assign rd_n      = !(rd_window && slot_free);
   assign take      = rd_window && slot_free && !rxf_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (take) begin
         valid_q <= 1'b1;
         data_q  <= bus_in;
      end else if (rx_ready) begin
         valid_q <= 1'b0;
      end
   end

   assign rx_valid = valid_q;
   assign rx_data  = data_q;
endmodule

// File: rtl/fbc_tx_stage.sv
module fbc_tx_stage #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_window,
   input  logic              txe_n,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              wr_n,
   output logic [DATA_W-1:0] bus_out,
   output logic              hold_valid,
   output logic              hold_next,
   output logic              wr_fire
);
   logic              hold_q;
   logic [DATA_W-1:0] data_q;
   logic              load;

   assign wr_fire   = wr_window && hold_q && !txe_n;
   assign tx_ready  = wr_window && (!hold_q || wr_fire);
   assign load      = tx_valid && tx_ready;
   assign hold_next = load || (hold_q && !wr_fire);
   assign wr_n      = !(wr_window && hold_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         data_q <= '0;
      end else begin
         hold_q <= hold_next;
         if (load) data_q <= tx_data;
      end
   end

   assign bus_out    = data_q;
   assign hold_valid = hold_q;
endmodule

// File: rtl/fifo_bridge_ctrl.sv
module fifo_bridge_ctrl
   import fbc_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned MAX_BURST = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dev_rxf_n,
   input  logic              dev_txe_n,
   output logic              dev_rd_n,
   output logic              dev_wr_n,
   output logic              dev_oe_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_drive,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic [DATA_W-1:0] rx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [DATA_W-1:0] tx_data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("fifo_bridge_ctrl: DATA_W must be at least 1");
      end
      if (MAX_BURST > 65535) begin : g_bad_burst
         $error("fifo_bridge_ctrl: MAX_BURST must not exceed 65535");
      end
   endgenerate

   fbc_state_t state;
   logic       hold_valid, hold_next, wr_fire;
   logic       rd_window, wr_window;

   assign rd_window = (state == ST_RD);
   assign wr_window = (state == ST_WR);
   assign dev_oe_n  = !((state == ST_RD_TURN) || (state == ST_RD));
   assign bus_drive = wr_window;

   fbc_sequencer #(.MAX_BURST(MAX_BURST)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .rxf_n      (dev_rxf_n),
      .txe_n      (dev_txe_n),
      .wr_pending (hold_valid || tx_valid),
      .hold_next  (hold_next),
      .wr_fire    (wr_fire),
      .state      (state)
   );

   fbc_rx_stage #(.DATA_W(DATA_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_window (rd_window),
      .rxf_n     (dev_rxf_n),
      .bus_in    (bus_in),
      .rx_ready  (rx_ready),
      .rd_n      (dev_rd_n),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data)
   );

   fbc_tx_stage #(.DATA_W(DATA_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_window  (wr_window),
      .txe_n      (dev_txe_n),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .tx_ready   (tx_ready),
      .wr_n       (dev_wr_n),
      .bus_out    (bus_out),
      .hold_valid (hold_valid),
      .hold_next  (hold_next),
      .wr_fire    (wr_fire)
   );
endmodule

// File: rtl/fbc_checker.sv
module fbc_checker #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dev_txe_n,
   input logic              dev_rd_n,
   input logic              dev_wr_n,
   input logic              dev_oe_n,
   input logic [DATA_W-1:0] bus_out,
   input logic              bus_drive,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic [DATA_W-1:0] rx_data
);
   a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> dev_oe_n);

   a_r3_rd_inside_oe: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_rd_n |-> !dev_oe_n);

   a_r3_oe_before_rd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dev_oe_n) |-> dev_rd_n);

   a_r6_wr_drives: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_wr_n |-> bus_drive);

   a_r6_gap_before_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dev_oe_n) |-> !$past(bus_drive));

   a_r6_gap_before_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_drive) |-> $past(dev_oe_n));

   a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

   a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |-> dev_rd_n);

   a_r10_retry_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!dev_wr_n && dev_txe_n) |=> $stable(bus_out));
endmodule

bind fifo_bridge_ctrl fbc_checker #(.DATA_W(DATA_W)) u_fbc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .dev_txe_n (dev_txe_n),
   .dev_rd_n  (dev_rd_n),
   .dev_wr_n  (dev_wr_n),
   .dev_oe_n  (dev_oe_n),
   .bus_out   (bus_out),
   .bus_drive (bus_drive),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .rx_data   (rx_data)
);

// File: tb/tb_fifo_bridge_ctrl.sv
`timescale 1ns/1ps
module tb_fifo_bridge_ctrl;
   localparam int W   = 8;
   localparam int LIM = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         dev_rxf_n = 1'b1, dev_txe_n = 1'b1;
   logic         dev_rd_n, dev_wr_n, dev_oe_n, bus_drive;
   logic [W-1:0] bus_in = 8'hEE, bus_out, rx_data;
   logic [W-1:0] tx_data = '0;
   logic         rx_valid, tx_ready;
   logic         rx_ready = 1'b0, tx_valid = 1'b0;

   fifo_bridge_ctrl #(.DATA_W(W), .MAX_BURST(LIM)) dut (
      .clk(clk), .rst_n(rst_n), .dev_rxf_n(dev_rxf_n), .dev_txe_n(dev_txe_n),
      .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_oe_n(dev_oe_n),
      .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data));

   int errors = 0, checks = 0;
   logic [W-1:0] dev_q[$], exp_rx[$], tx_pend[$];
   int rdy_pct = 100, rxf_stall_pct = 0, txe_stall_pct = 0;
   bit force_txe_hi = 0, tx_hs = 0;
   int tx_left = 0, rx_got = 0, tx_got = 0, retries = 0, run = 0;
   logic [W-1:0] tx_seq = 8'h40, rx_seq = 8'h10;
   logic prev_drive = 0, prev_rxf = 1, prev_txe = 1, prev_oe = 1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive_in();
      bit stall;
      stall     = ($urandom_range(99) < rxf_stall_pct);
      dev_rxf_n = (dev_q.size() == 0) || stall;
      bus_in    = dev_rxf_n ? 8'hEE : dev_q[0];
      dev_txe_n = force_txe_hi || ($urandom_range(99) < txe_stall_pct);
      rx_ready  = ($urandom_range(99) < rdy_pct);
      if (tx_hs) begin tx_valid = 1'b0; tx_hs = 0; end
      if (!tx_valid && tx_left > 0 && $urandom_range(3) != 0) begin
         tx_valid = 1'b1; tx_data = tx_seq; tx_seq++; tx_left--;
      end
   endtask

   task automatic eval();
      logic [W-1:0] e;
      chk(!(bus_drive && !dev_oe_n), "R6 drive while OE low", bus_drive, 0);
      chk(dev_rd_n || !dev_oe_n, "R3 RD low outside OE", dev_rd_n, 1);
      chk(rx_valid == (exp_rx.size() != 0), "R5 rx_valid vs model", rx_valid, exp_rx.size() != 0);
      if (rx_valid && !rx_ready) chk(dev_rd_n, "R7 RD released under back-pressure", dev_rd_n, 1);
      if (bus_drive && !prev_drive)
         chk(prev_rxf && !prev_txe, "R8 write start with read pending or device full", {prev_rxf, prev_txe}, 2'b10);
      chk(!((bus_drive && !prev_oe) || (!dev_oe_n && prev_drive)), "R6 no idle cycle at turnaround",
          {prev_drive, bus_drive, prev_oe, dev_oe_n}, 0);
      if (rx_valid && rx_ready) begin
         e = (exp_rx.size() != 0) ? exp_rx[0] : 'x;
         chk(exp_rx.size() != 0 && rx_data == e, "R2 received byte order", rx_data, e);
         if (exp_rx.size() != 0) void'(exp_rx.pop_front());
         rx_got++;
      end
      if (!dev_rd_n && !dev_rxf_n) exp_rx.push_back(dev_q.pop_front());
      if (!bus_drive) run = 0;
      if (!dev_wr_n && !dev_txe_n) begin
         e = (tx_pend.size() != 0) ? tx_pend[0] : 'x;
         chk(tx_pend.size() != 0 && bus_out == e, "R4 written byte order", bus_out, e);
         if (tx_pend.size() != 0) void'(tx_pend.pop_front());
         tx_got++; run++;
         chk(run <= LIM, "R9 write visit length", run, LIM);
      end
      if (!dev_wr_n && dev_txe_n) retries++;
      if (tx_valid && tx_ready) begin tx_pend.push_back(tx_data); tx_hs = 1; end
      prev_drive = bus_drive; prev_rxf = dev_rxf_n; prev_txe = dev_txe_n; prev_oe = dev_oe_n;
   endtask

   task automatic step();
      @(negedge clk); drive_in(); #1; eval();
   endtask

   task automatic load_rx(input int n);
      for (int i = 0; i < n; i++) begin dev_q.push_back(rx_seq); rx_seq++; end
   endtask

   task automatic run_done(input int cap);
      for (int i = 0; i < cap; i++) begin
         step();
         if (dev_q.size() == 0 && exp_rx.size() == 0 && tx_left == 0 && !tx_valid &&
             tx_pend.size() == 0 && !rx_valid) break;
      end
      chk(dev_q.size() == 0 && exp_rx.size() == 0, "R2 all received bytes delivered", dev_q.size() + exp_rx.size(), 0);
      chk(tx_left == 0 && tx_pend.size() == 0, "R4 all sent bytes accepted", tx_pend.size(), 0);
   endtask

   initial begin
      #(200000 * 4);
      errors++; checks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state, even with both flags asserting activity
      dev_rxf_n = 1'b0; dev_txe_n = 1'b0; tx_valid = 1'b1; tx_data = 8'h99;
      repeat (3) @(negedge clk);
      #1;
      chk({dev_rd_n, dev_wr_n, dev_oe_n, bus_drive} == 4'b1110, "R1 outputs in reset",
          {dev_rd_n, dev_wr_n, dev_oe_n, bus_drive}, 4'b1110);
      tx_valid = 1'b0; dev_rxf_n = 1'b1; dev_txe_n = 1'b1;
      @(negedge clk); rst_n = 1'b1;

      // read burst, user always ready
      load_rx(20); run_done(400);
      // read with back-pressure and device stalls
      rdy_pct = 50; rxf_stall_pct = 20; load_rx(25); run_done(1000);
      // write only, with device-full stalls (retries)
      rdy_pct = 100; rxf_stall_pct = 0; txe_stall_pct = 30; tx_left = 30; run_done(1000);
      // mixed traffic, long write bursts against the limit
      txe_stall_pct = 5; rxf_stall_pct = 30; rdy_pct = 70; tx_left = 40; load_rx(30); run_done(2000);
      chk(retries > 0, "R10 retry path exercised", retries, 1);

      // R10 + R1: byte refused while device full, then reset discards it
      txe_stall_pct = 0; rxf_stall_pct = 0; rdy_pct = 100; tx_left = 1;
      for (int i = 0; i < 50 && tx_pend.size() == 0; i++) step();
      force_txe_hi = 1;
      step();
      chk(!dev_wr_n && dev_txe_n, "R10 byte presented while device full", {dev_wr_n, dev_txe_n}, 2'b01);
      chk(tx_pend.size() == 1 && bus_out == tx_pend[0], "R10 presented byte", bus_out, tx_pend[0]);
      step(); step();
      chk(dev_wr_n && bus_out == tx_pend[0], "R10 refused byte kept", bus_out, tx_pend[0]);
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      tx_pend.delete(); force_txe_hi = 0;
      prev_drive = 0; prev_oe = 1; prev_rxf = 1; prev_txe = 1;
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
         step();
         chk(dev_wr_n && !bus_drive, "R1 retry byte cleared by reset", {dev_wr_n, bus_drive}, 2'b10);
      end

      // traffic resumes normally after the reset
      tx_left = 10; load_rx(10); run_done(500);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule